// File: doc/BRIEF.md
# I2S Transmit Serializer with Underrun Substitution

This block turns stereo audio words written by software into a single I2S serial data stream. A separate timing block supplies a one-cycle strobe for every falling edge of the serial bit clock, together with the word-select level. The serializer detects each word-select transition, loads the word for the new slot and shifts it out MSB first. The first data bit appears one bit clock after the transition. Data therefore changes only on falling bit-clock edges, and a receiver samples it on the rising edge.

Software writes through a single holding register. A ready flag shows that the register is empty. When a slot starts and no fresh word is waiting, the block raises a sticky underrun flag. It then sends either an all-zero word or a replay of the last word it sent for that same channel, which it keeps in a per-channel history. A compact mode packs both 16-bit channel samples into one write, so one write serves a whole frame.

Top module: `i2stx_serializer`

## Requirements
- R1: After reset, `tx_ready` is 1, `urun_flag` is 0 and `sd` is 0.
- R2: A write (`wr_en` high) clears `tx_ready` on the next cycle. Loading the held word at a slot start sets `tx_ready` again.
- R3: On the strobe where `ws` changes, the block loads a new slot. The MSB of the new word (bit SLOT_W-1) is driven on `sd` at the next strobe, and the following bits come out one per strobe in descending order. `ws`=0 is the left channel and `ws`=1 is the right channel. `sd` changes only on a strobe.
- R4: When a slot is shorter than SLOT_W bit clocks, the low-order bits that do not fit are dropped, and the next slot starts with its own MSB.
- R5: When a slot is longer than SLOT_W bit clocks, the bit times after the LSB are driven 0.
- R6: If a slot that needs a written word starts while the holding register is empty, `urun_flag` is set. It stays set until a cycle with `urun_clr` high, and a set in the same cycle takes priority over the clear.
- R7: On underrun with `repeat_en`=0, the slot carries an all-zero word.
- R8: On underrun with `repeat_en`=1, the slot carries the last word sent on that same channel. Left and right keep separate histories.
- R9: With `compact`=1, one write feeds a whole frame. Bits [15:0] go to the left slot and bits [31:16] go to the right slot, each placed in the top 16 bit times of its slot. Only the left slot start consumes the write and can raise underrun. The right slot uses the upper half kept from that write, or the substitute word if the left slot underran.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_fall | input | 1 | One-cycle strobe per falling bit-clock edge |
| ws | input | 1 | Word select level (0 = left, 1 = right) |
| compact | input | 1 | Two 16-bit samples per written word |
| repeat_en | input | 1 | Replay the previous word of the same channel on underrun |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | WORD_W | Word written to the holding register |
| urun_clr | input | 1 | Clears the underrun flag |
| tx_ready | output | 1 | Holding register empty |
| urun_flag | output | 1 | Sticky transmit underrun flag |
| sd | output | 1 | Serial data out |

## Verification
The hardest case to reach is a replay on underrun. It needs a history of two different words that were sent earlier, one per channel, followed by two slot starts with an empty holding register. The bench first writes distinct left and right words with repeat enabled, then skips writes for a full frame and compares each serial bit with the earlier words. Slots of 20 and 28 bit clocks push the shifter past both ends of the word, and a compact frame followed by an unwritten frame exercises the kept upper half and its loss on underrun.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
  localparam int HALF_W = 16;
endpackage

// File: rtl/i2stx_ws_edge.sv
module i2stx_ws_edge
  import i2stx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_fall,
  input  logic  ws,
  output logic  slot_start,
  output chan_e slot_ch
);
  logic ws_q, ws_d;

  always_comb ws_d = sck_fall ? ws : ws_q;

  // starts high so the first low level opens a left slot
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ws_q <= 1'b1;
    else        ws_q <= ws_d;

  assign slot_start = sck_fall && (ws != ws_q);
  assign slot_ch    = chan_e'(ws);
endmodule

// File: rtl/i2stx_hold.sv
module i2stx_hold #(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  input  logic              split,
  input  logic              drop_hi,
  output logic              full,
  output logic [WORD_W-1:0] data_q,
  output logic              hi_v,
  output logic [HALF_W-1:0] hi_q
);
  logic              full_q, full_d, hi_v_q, hi_v_d;
  logic [WORD_W-1:0] data_d;
  logic [HALF_W-1:0] hi_d;

  always_comb begin
    full_d = full_q;
    if (take)  full_d = 1'b0;
    if (wr_en) full_d = 1'b1;
    data_d = wr_en ? wr_data : data_q;
    hi_v_d = hi_v_q;
    hi_d   = hi_q;
    if (drop_hi) hi_v_d = 1'b0;
    if (split) begin
      hi_v_d = 1'b1;
      hi_d   = data_q[2*HALF_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      hi_v_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      hi_v_q <= hi_v_d;
      hi_q   <= hi_d;
    end

  assign full = full_q;
  assign hi_v = hi_v_q;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full); // R2
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wr_en |=> !full); // R2
endmodule

// File: rtl/i2stx_pick.sv
module i2stx_pick
  import i2stx_pkg::*;
#(
  parameter int SLOT_W = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  chan_e             slot_ch,
  input  logic              compact,
  input  logic              repeat_en,
  input  logic              full,
  input  logic [WORD_W-1:0] hold_data,
  input  logic              hi_v,
  input  logic [HALF_W-1:0] hi_data,
  input  logic              urun_clr,
  output logic              take,
  output logic              split,
  output logic              drop_hi,
  output logic [SLOT_W-1:0] load_word,
  output logic              urun_flag
);
  localparam int PAD = SLOT_W - HALF_W;

  logic                   need, urun_set, fresh_ok, urun_q, urun_d;
  logic [SLOT_W-1:0]      fresh, subst;
  logic [1:0][SLOT_W-1:0] hist_all;

  always_comb begin
    need     = slot_start && (!compact || slot_ch == CH_LEFT);
    take     = need && full;
    split    = take && compact;
    urun_set = need && !full;
    drop_hi  = slot_start && compact && (slot_ch == CH_RIGHT);
    subst    = repeat_en ? hist_all[slot_ch] : '0;
    if (!compact) begin
      fresh_ok = full;
      fresh    = hold_data[SLOT_W-1:0];
    end else if (slot_ch == CH_LEFT) begin
      fresh_ok = full;
      fresh    = SLOT_W'(hold_data[HALF_W-1:0]) << PAD;
    end else begin
      fresh_ok = hi_v;
      fresh    = SLOT_W'(hi_data) << PAD;
    end
    load_word = fresh_ok ? fresh : subst;
    urun_d    = urun_q;
    if (urun_clr) urun_d = 1'b0;
    if (urun_set) urun_d = 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_hist
    logic [SLOT_W-1:0] q;
    logic              en;
    assign en = slot_start && (int'(slot_ch) == g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  q <= '0;
      else if (en) q <= load_word;
    assign hist_all[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) urun_q <= 1'b0;
    else        urun_q <= urun_d;

  assign urun_flag = urun_q;

  AST_URUN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !compact && !full |=> urun_flag); // R6
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    urun_flag && !urun_clr |=> urun_flag); // R6
  AST_REPLAY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !compact && !full && repeat_en |=> $stable(hist_all)); // R8
endmodule

// File: rtl/i2stx_shift.sv
module i2stx_shift #(
  parameter int SLOT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              slot_start,
  input  logic [SLOT_W-1:0] load_word,
  output logic              sd,
  output logic [SLOT_W-1:0] sh_q
);
  logic [SLOT_W-1:0] sh_d;
  logic              sd_q, sd_d;

  always_comb begin
    sh_d = sh_q;
    if (sck_fall)   sh_d = {sh_q[SLOT_W-2:0], 1'b0};
    if (slot_start) sh_d = load_word;
    sd_d = sck_fall ? sh_q[SLOT_W-1] : sd_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
    end

  assign sd = sd_q;

  AST_SD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sd)); // R3
  AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> sh_q == $past(load_word)); // R3
endmodule

// File: rtl/i2stx_serializer.sv
module i2stx_serializer
  import i2stx_pkg::*;
#(
  parameter int SLOT_W = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              ws,
  input  logic              compact,
  input  logic              repeat_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              urun_clr,
  output logic              tx_ready,
  output logic              urun_flag,
  output logic              sd
);
  logic [1:0]        rs_q;
  logic              rst_s;
  logic              slot_start, take, split, drop_hi, full, hi_v;
  chan_e             slot_ch;
  logic [WORD_W-1:0] hold_data;
  logic [HALF_W-1:0] hi_data;
  logic [SLOT_W-1:0] load_word, sh_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_s = rs_q[1];

  i2stx_ws_edge u_edge (
    .clk(clk), .rst_n(rst_s), .sck_fall(sck_fall), .ws(ws),
    .slot_start(slot_start), .slot_ch(slot_ch));

  i2stx_hold #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_hold (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .split(split), .drop_hi(drop_hi), .full(full),
    .data_q(hold_data), .hi_v(hi_v), .hi_q(hi_data));

  i2stx_pick #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_pick (
    .clk(clk), .rst_n(rst_s), .slot_start(slot_start), .slot_ch(slot_ch),
    .compact(compact), .repeat_en(repeat_en), .full(full),
    .hold_data(hold_data), .hi_v(hi_v), .hi_data(hi_data),
    .urun_clr(urun_clr), .take(take), .split(split), .drop_hi(drop_hi),
    .load_word(load_word), .urun_flag(urun_flag));

  i2stx_shift #(.SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .sck_fall(sck_fall), .slot_start(slot_start),
    .load_word(load_word), .sd(sd), .sh_q(sh_q));

  assign tx_ready = !full;

  AST_ZERO_SUBST: assert property (@(posedge clk) disable iff (!rst_s)
    slot_start && !compact && tx_ready && !repeat_en |=> sh_q == '0); // R7
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_s)
    slot_start && !compact && !tx_ready && !wr_en |=> tx_ready); // R2
endmodule

// File: tb/test_i2stx_serializer.sv
module test_i2stx_serializer;
  logic        clk = 1'b0;
  logic        rst_n, sck_fall, ws, compact, repeat_en, wr_en, urun_clr;
  logic [31:0] wr_data;
  logic        tx_ready, urun_flag, sd;

  int          total = 0;
  int          bad = 0;
  logic        exp_q[$];
  string       tag_q[$];
  logic [23:0] pimg = 24'h0;
  int          pn = 24;

  always #4 clk = ~clk;

  i2stx_serializer i_i2stx_serializer (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .ws(ws),
    .compact(compact), .repeat_en(repeat_en), .wr_en(wr_en),
    .wr_data(wr_data), .urun_clr(urun_clr), .tx_ready(tx_ready),
    .urun_flag(urun_flag), .sd(sd));

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected bit per strobe
  initial forever begin
    @(posedge clk);
    if (sck_fall === 1'b1) begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, sd, e, "sd bit");
      end
    end
  end

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2", tx_ready, 1'b0, "ready after write");
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    ws = v;
    sck_fall = 1'b1;
    @(negedge clk);
    sck_fall = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_slot(input logic v, input int n, input logic wr, input logic [31:0] d,
                          input logic [23:0] img, input string tag, input logic exp_urun);
    if (wr) do_write(d);
    for (int i = 0; i < n; i++) begin
      logic e;
      if (i == 0) e = (pn <= 24) ? pimg[24-pn] : 1'b0;
      else        e = (i <= 24) ? img[24-i] : 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      tick(v);
      if (i == 0) begin
        chk("R2", tx_ready, 1'b1, "ready after slot load");
        chk("R6", urun_flag, exp_urun, "underrun flag at slot start");
      end
    end
    pimg = img;
    pn = n;
  endtask

  task automatic clear_urun();
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    chk("R6", urun_flag, 1'b0, "flag after clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck_fall = 1'b0; ws = 1'b1; compact = 1'b0; repeat_en = 1'b0;
    wr_en = 1'b0; wr_data = '0; urun_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", tx_ready, 1'b1, "ready at reset");
    chk("R1", urun_flag, 1'b0, "underrun at reset");
    chk("R1", sd, 1'b0, "sd at reset");

    // plain 24-bit slots, bit order and channel placement
    run_slot(1'b0, 24, 1'b1, 32'h00ABCDEF, 24'hABCDEF, "R3", 1'b0);
    run_slot(1'b1, 24, 1'b1, 32'h00123456, 24'h123456, "R3", 1'b0);
    // short slot drops low bits, long slot pads with zeros
    run_slot(1'b0, 20, 1'b1, 32'h00F0F0F0, 24'hF0F0F0, "R4", 1'b0);
    run_slot(1'b1, 28, 1'b1, 32'h00FFFFFF, 24'hFFFFFF, "R5", 1'b0);
    // underrun with zero substitution
    run_slot(1'b0, 24, 1'b0, 32'h0, 24'h000000, "R7", 1'b1);
    run_slot(1'b1, 24, 1'b0, 32'h0, 24'h000000, "R7", 1'b1);
    chk("R6", urun_flag, 1'b1, "flag still set without clear");
    clear_urun();

    // underrun with replay of the same channel
    @(negedge clk) repeat_en = 1'b1;
    run_slot(1'b0, 24, 1'b1, 32'h00111111, 24'h111111, "R8", 1'b0);
    run_slot(1'b1, 24, 1'b1, 32'h00EEEEEE, 24'hEEEEEE, "R8", 1'b0);
    run_slot(1'b0, 24, 1'b0, 32'h0, 24'h111111, "R8", 1'b1);
    run_slot(1'b1, 24, 1'b0, 32'h0, 24'hEEEEEE, "R8", 1'b1);
    clear_urun();

    // compact: one write feeds both channels
    @(negedge clk) begin repeat_en = 1'b0; compact = 1'b1; end
    run_slot(1'b0, 24, 1'b1, 32'hBEEF1234, 24'h123400, "R9", 1'b0);
    run_slot(1'b1, 24, 1'b0, 32'h0, 24'hBEEF00, "R9", 1'b0);
    run_slot(1'b0, 24, 1'b0, 32'h0, 24'h000000, "R9", 1'b1);
    run_slot(1'b1, 24, 1'b0, 32'h0, 24'h000000, "R9", 1'b1);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule